// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Seconds Snapshot

This block keeps wall time as two free-running counters: a seconds count and a milliseconds count that steps once for every pulse on a 1 kHz tick enable. The counters never stop on their own, so the block can serve as a time base that keeps counting while the rest of the system sleeps. Software sees three word registers through a plain read/write port with a one-cycle registered read.

Software often needs a timestamp from two reads, and the seconds value can change between them. To avoid this, every accepted read of the milliseconds register also copies the seconds value of that same cycle into a separate snapshot register. Software reads milliseconds first and then the snapshot. It forms the time as snapshot × 1000 + milliseconds and treats the result as a wrapping 32-bit count. Writing the seconds register sets the time to a whole second.

Top module: `msrtc_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, the seconds count, the milliseconds count, the snapshot and `rdata` are all zero.
- R2: Each cycle with `tick_ms` high steps the milliseconds count by one while it is below 999. A cycle without a tick leaves both counts unchanged. The milliseconds count never exceeds 999.
- R3: A tick while the milliseconds count is 999 sets it to 0 and raises the seconds count by one in the same cycle.
- R4: A read (`rd_en` high) at offset 0x10 returns the milliseconds count on `rdata` in the following cycle. In that same cycle the snapshot is loaded with the seconds count. `rdata` holds its value in cycles with no read.
- R5: When a milliseconds read and a rollover tick fall in the same cycle, the read returns 999 and the snapshot takes the seconds value from before the increment. The pair is therefore consistent.
- R6: A read at offset 0x08 returns the live seconds count and a read at 0x0c returns the snapshot. A read at any other offset returns zero. Reads at 0x08 and 0x0c do not change the snapshot.
- R7: A write (`wr_en` high) at offset 0x08 loads the seconds count from `wdata` and clears the milliseconds count. This write takes priority over a tick in the same cycle.
- R8: Writes at 0x0c or 0x10 change neither counter nor the snapshot.
- R9: The seconds count wraps from 0xFFFFFFFF to 0 on rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| rd_en | input | 1 | Read strobe for `addr` |
| wr_en | input | 1 | Write strobe for `addr` |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |

## Verification
The checker watches the counters on every cycle. It covers the milliseconds range and its single step, the rollover carry into seconds, the hold when no tick arrives, the snapshot load on a milliseconds read, and the snapshot holding at all other times. It also checks that a seconds write takes priority over a tick. Some behaviours can only be shown by the bench's scenarios, with the reference model run every clock: the coherence of a millisecond read that coincides with a rollover, zero data for unmapped offsets, ignored writes to the read-only offsets, and the wrap of the seconds count after a full second from all ones.

// File: rtl/msrtc_pkg.sv
package msrtc_pkg;

    localparam logic [31:0] OFS_SECONDS  = 32'h08;
    localparam logic [31:0] OFS_SNAPSHOT = 32'h0c;
    localparam logic [31:0] OFS_MILLIS   = 32'h10;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_SECONDS,
        SEL_SNAPSHOT,
        SEL_MILLIS
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [31:0] a);
        reg_sel_e s;
        case (a)
            OFS_SECONDS:  s = SEL_SECONDS;
            OFS_SNAPSHOT: s = SEL_SNAPSHOT;
            OFS_MILLIS:   s = SEL_MILLIS;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/msrtc_counter.sv
module msrtc_counter #(
    parameter int SEC_W      = 32,
    parameter int MS_PER_SEC = 1000,
    parameter int MS_W       = $clog2(MS_PER_SEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    output logic [SEC_W-1:0] sec_q,
    output logic [MS_W-1:0]  ms_q
);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= '0;
            ms_q  <= '0;
        end else if (load) begin
            sec_q <= load_val;
            ms_q  <= '0;
        end else if (tick) begin
            if (ms_q == MS_LAST) begin
                ms_q  <= '0;
                sec_q <= sec_q + SEC_W'(1);
            end else begin
                ms_q <= ms_q + MS_W'(1);
            end
        end
    end
endmodule

// File: rtl/msrtc_snapshot.sv
module msrtc_snapshot #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [SEC_W-1:0] sec_in,
    output logic [SEC_W-1:0] snap_q
);
    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= '0;
        else if (capture)
            snap_q <= sec_in;
    end
endmodule

// File: rtl/msrtc_rdmux.sv
module msrtc_rdmux
    import msrtc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MS_W   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] sec,
    input  logic [DATA_W-1:0] snap,
    input  logic [MS_W-1:0]   ms,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        case (sel)
            SEL_SECONDS:  rd_next = sec;
            SEL_SNAPSHOT: rd_next = snap;
            SEL_MILLIS:   rd_next = DATA_W'(ms);
            default:      rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_next;
    end
endmodule

// File: rtl/msrtc_top.sv
module msrtc_top
    import msrtc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int MS_PER_SEC = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_ms,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int MS_W = $clog2(MS_PER_SEC);

    reg_sel_e          sel;
    logic              sec_load;
    logic              snap_take;
    logic [DATA_W-1:0] sec_q;
    logic [MS_W-1:0]   ms_q;
    logic [DATA_W-1:0] snap_q;

    assign sel       = decode_addr(32'(addr));
    assign sec_load  = wr_en && (sel == SEL_SECONDS);
    assign snap_take = rd_en && (sel == SEL_MILLIS);

    msrtc_counter #(
        .SEC_W(DATA_W), .MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)
    ) u_cnt (
        .clk(clk), .rst(rst), .tick(tick_ms), .load(sec_load),
        .load_val(wdata), .sec_q(sec_q), .ms_q(ms_q)
    );

    msrtc_snapshot #(.SEC_W(DATA_W)) u_snap (
        .clk(clk), .rst(rst), .capture(snap_take),
        .sec_in(sec_q), .snap_q(snap_q)
    );

    msrtc_rdmux #(.DATA_W(DATA_W), .MS_W(MS_W)) u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel),
        .sec(sec_q), .snap(snap_q), .ms(ms_q), .rdata(rdata)
    );
endmodule

// File: rtl/msrtc_chk.sv
module msrtc_chk
    import msrtc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int MS_PER_SEC = 1000,
    parameter int MS_W       = $clog2(MS_PER_SEC)
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_ms,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] sec_q,
    input logic [MS_W-1:0]   ms_q,
    input logic [DATA_W-1:0] snap_q
);
    localparam logic [MS_W-1:0] LAST = MS_W'(MS_PER_SEC - 1);

    logic wr_s, rd_m;
    assign wr_s = wr_en && (decode_addr(32'(addr)) == SEL_SECONDS);
    assign rd_m = rd_en && (decode_addr(32'(addr)) == SEL_MILLIS);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (sec_q == '0 && ms_q == '0 && snap_q == '0 && rdata == '0)); // R1
    AST_MS_RANGE: assert property (@(posedge clk) disable iff (rst)
        ms_q <= LAST); // R2
    AST_MS_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick_ms && !wr_s && ms_q != LAST) |=> (ms_q == $past(ms_q) + MS_W'(1) && $stable(sec_q))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_ms && !wr_s) |=> ($stable(ms_q) && $stable(sec_q))); // R2
    AST_ROLLOVER: assert property (@(posedge clk) disable iff (rst)
        (tick_ms && !wr_s && ms_q == LAST) |=> (ms_q == '0 && sec_q == $past(sec_q) + DATA_W'(1))); // R3
    AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (rst)
        rd_m |=> (snap_q == $past(sec_q))); // R4
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_m |=> $stable(snap_q)); // R6
    AST_SEC_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_s |=> (sec_q == $past(wdata) && ms_q == '0)); // R7
endmodule

bind msrtc_top msrtc_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)
) u_chk (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .sec_q(sec_q), .ms_q(ms_q),
    .snap_q(snap_q)
);

// File: tb/sim_msrtc_top.sv
module sim_msrtc_top;
    localparam logic [7:0] A_SEC  = 8'h08;
    localparam logic [7:0] A_SNAP = 8'h0c;
    localparam logic [7:0] A_MS   = 8'h10;
    localparam logic [7:0] A_BAD  = 8'h04;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_ms = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] m_sec = '0, m_ms = '0, m_snap = '0, m_rd = '0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    msrtc_top u0 (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rdata=%0h expected %0h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, advance the model, compare at next negedge
    task automatic step(input bit t, input bit r, input bit w,
                        input logic [7:0] a, input logic [31:0] d);
        tick_ms = t; rd_en = r; wr_en = w; addr = a; wdata = d;
        if (r) begin
            if (a == A_SEC)       m_rd = m_sec;
            else if (a == A_SNAP) m_rd = m_snap;
            else if (a == A_MS) begin m_rd = m_ms; m_snap = m_sec; end
            else                  m_rd = 32'h0;
        end
        if (w && a == A_SEC) begin
            m_sec = d; m_ms = 0;
        end else if (t) begin
            if (m_ms == 999) begin m_ms = 0; m_sec = m_sec + 1; end
            else m_ms = m_ms + 1;
        end
        @(negedge clk);
        check(cur_req, rdata, m_rd);
    endtask

    task automatic rd(input logic [7:0] a);
        step(0, 1, 0, a, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, A_BAD, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: rdata=%0h expected completion", rdata);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick_ms = 1'b1; rd_en = 1'b1; addr = A_MS;
        @(negedge clk); @(negedge clk);
        check("R1", rdata, 32'h0);
        tick_ms = 1'b0; rd_en = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1", rdata, 32'h0);
        cur_req = "R1";
        rd(A_SEC); rd(A_SNAP); rd(A_MS);

        cur_req = "R2";
        ticks(5); rd(A_MS);
        for (int i = 0; i < 4; i++) step(0, 0, 0, A_BAD, 0);
        rd(A_MS); rd(A_SEC);

        cur_req = "R3";
        ticks(995); rd(A_MS); rd(A_SEC);
        ticks(1); rd(A_MS); rd(A_SEC);

        cur_req = "R4";
        ticks(37); rd(A_MS); rd(A_SNAP);
        ticks(3); rd(A_SNAP);

        cur_req = "R5";
        while (m_ms != 999) step(1, 0, 0, A_BAD, 0);
        step(1, 1, 0, A_MS, 0);
        rd(A_SNAP); rd(A_SEC); rd(A_MS);

        cur_req = "R6";
        rd(A_BAD); rd(8'h14); rd(8'h00);
        ticks(1000); rd(A_SEC); rd(A_SNAP); rd(A_SNAP);

        cur_req = "R7";
        ticks(20);
        step(1, 0, 1, A_SEC, 32'd100);
        rd(A_MS); rd(A_SEC);
        ticks(2); rd(A_MS);

        cur_req = "R8";
        rd(A_MS);
        step(0, 0, 1, A_SNAP, 32'h1234_5678);
        step(0, 0, 1, A_MS, 32'd500);
        rd(A_SNAP); rd(A_MS); rd(A_SEC);

        cur_req = "R9";
        step(0, 0, 1, A_SEC, 32'hFFFF_FFFF);
        ticks(999); rd(A_SEC);
        ticks(1); rd(A_SEC); rd(A_MS);

        cur_req = "R4";
        for (int i = 0; i < 1500; i++)
            step(i % 3 != 0, i % 7 == 0 || i % 7 == 3, 1'b0,
                 (i % 2 == 0) ? A_MS : A_SNAP, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule